// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between the execute stage and the data memory write port. It holds stores in program order, from allocation until their memory write completes, so that later loads can run ahead of them. Each entry keeps an address, a byte size, a data word and two flags that say whether the address and the data are known yet. Either value may be filled in after allocation, addressed by the tag the block hands out at allocation.

Every load is compared against all buffered stores, which are all older than the load. The youngest store that could touch the load's bytes decides the outcome. The load reads memory directly, or takes its data straight from that store, or is blocked. Blocked loads are counted, both in total and by reason.

Stores retire in order. The oldest store goes to the memory write port once it is retired and complete, in whatever cycles the port accepts it. Its entry frees when the write handshake completes.

Top module: `stb_fwd`

## Requirements
- R1: After reset the buffer is empty. `st_ready_o` is 1 and `mem_wr_valid_o` is 0. All four counters are 0, and a load returns result code 0 (pass).
- R2: A load overlaps a store when the byte ranges [addr, addr+bytes) intersect, with no address wrap-around. Size codes are 0 = 1 byte, 1 = 2 bytes, and 2 or 3 = 4 bytes. A load that overlaps no buffered store, with no buffered store of unknown address, returns code 0 (pass), why code 0 and data 0.
- R3: A load forwards (code 1) when the deciding store has known data, starts at the load address and is at least as large as the load. The data is that store's low load-size bytes, zero-extended to 32 bits.
- R4: The buffered stores are scanned from youngest to oldest. The first one that overlaps the load, or whose address is unknown, decides the outcome. Older stores have no effect.
- R5: A blocked load returns code 2 with a why code. Why code 1 means the deciding store's address is unknown. Why code 2 means it overlaps but its data is unknown. Why code 3 means it overlaps with a different start address or a smaller size. A load that is not blocked returns why code 0.
- R6: In every cycle with `ld_valid_i` high and a blocked result, the total block counter and the counter for that reason each increase by 1. When `ld_valid_i` is low, no counter changes.
- R7: The oldest entry is offered on the memory write port only once it is retired and complete. It stays unchanged until `mem_wr_ready_i`, and entries leave in allocation order.
- R8: `retire_i` marks the oldest store not yet retired. If every buffered store is already retired, `retire_i` is ignored.
- R9: With 8 entries held, `st_ready_o` is low and an offered store is not taken. The tag output gives the entry index the next store will use, cycling 0 to 7.
- R10: An address fill or data fill takes effect only on an allocated entry whose field is still unknown. A fill on a free tag is ignored.
- R11: A load in the same cycle as the memory write handshake of the store it hits still sees that store. From the next cycle the store is gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store allocation request |
| st_ready_o | output | 1 | Buffer can take a store |
| st_addr_i | input | AW | Store byte address |
| st_addr_vld_i | input | 1 | Store address known at allocation |
| st_data_i | input | 32 | Store data, low bytes used |
| st_data_vld_i | input | 1 | Store data known at allocation |
| st_size_i | input | 2 | Store size code |
| st_tag_o | output | IW | Entry index for the next allocation |
| af_valid_i | input | 1 | Late address fill |
| af_tag_i | input | IW | Entry receiving the address |
| af_addr_i | input | AW | Filled address |
| df_valid_i | input | 1 | Late data fill |
| df_tag_i | input | IW | Entry receiving the data |
| df_data_i | input | 32 | Filled data |
| retire_i | input | 1 | Retire the oldest unretired store |
| mem_wr_valid_o | output | 1 | Memory write offered |
| mem_wr_ready_i | input | 1 | Memory port idle, accepts the write |
| mem_wr_addr_o | output | AW | Write address |
| mem_wr_size_o | output | 2 | Write size code |
| mem_wr_data_o | output | 32 | Write data |
| ld_valid_i | input | 1 | Load lookup valid, enables counting |
| ld_addr_i | input | AW | Load byte address |
| ld_size_i | input | 2 | Load size code |
| ld_res_o | output | 2 | 0 pass, 1 forward, 2 block |
| ld_why_o | output | 2 | Block reason code |
| ld_data_o | output | 32 | Forwarded data, else 0 |
| blk_cnt_o | output | CW | Total blocked loads |
| blk_addr_cnt_o | output | CW | Blocks from unknown address |
| blk_data_cnt_o | output | CW | Blocks from unknown data |
| blk_part_cnt_o | output | CW | Blocks from misaligned or partial overlap |

## Verification
The load lookup and the drain of the oldest entry can fall in the same cycle. A retired, complete store is held on the write port with ready low. A load is then aimed at that store's address in the very cycle that ready rises. The bench expects a forward in the handshake cycle and a pass in the cycle after. Its queue-based model removes the store only at the clock edge, so the lookup in the handshake cycle still sees it.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int DW = 32;

  typedef enum logic [1:0] {
    LD_PASS = 2'd0,
    LD_FWD  = 2'd1,
    LD_BLK  = 2'd2
  } ld_res_e;

  typedef enum logic [1:0] {
    WHY_NONE = 2'd0,
    WHY_ADDR = 2'd1,
    WHY_DATA = 2'd2,
    WHY_PART = 2'd3
  } blk_why_e;

  function automatic logic [2:0] sz_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/stb_entries.sv
module stb_entries import stb_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int AW = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int NW = IW + 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       alloc_i,
  input  logic [AW-1:0]              alloc_addr_i,
  input  logic                       alloc_av_i,
  input  logic [DW-1:0]              alloc_data_i,
  input  logic                       alloc_dv_i,
  input  logic [1:0]                 alloc_size_i,
  input  logic                       af_valid_i,
  input  logic [IW-1:0]              af_tag_i,
  input  logic [AW-1:0]              af_addr_i,
  input  logic                       df_valid_i,
  input  logic [IW-1:0]              df_tag_i,
  input  logic [DW-1:0]              df_data_i,
  input  logic                       retire_i,
  input  logic                       wr_done_i,
  output logic                       full_o,
  output logic [IW-1:0]              head_o,
  output logic [IW-1:0]              tail_o,
  output logic [DEPTH-1:0]           vld_o,
  output logic [DEPTH-1:0]           av_o,
  output logic [DEPTH-1:0]           dv_o,
  output logic [DEPTH-1:0]           rtd_o,
  output logic [DEPTH-1:0][AW-1:0]   addr_o,
  output logic [DEPTH-1:0][DW-1:0]   data_o,
  output logic [DEPTH-1:0][1:0]      size_o
);
  logic [DEPTH-1:0]         vld_q, av_q, dv_q, rtd_q;
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;
  logic [DEPTH-1:0][1:0]    size_q;
  logic [IW-1:0]            head_q, tail_q, rptr_q;
  logic [NW-1:0]            cnt_q;
  logic                     ret_go;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // rptr sits on the oldest unretired entry, or on a free slot when none is left
  assign ret_go = retire_i & vld_q[rptr_q] & ~rtd_q[rptr_q];
  assign full_o = (cnt_q == NW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      av_q   <= '0;
      dv_q   <= '0;
      rtd_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      size_q <= '0;
      head_q <= '0;
      tail_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (af_valid_i && vld_q[af_tag_i] && !av_q[af_tag_i]) begin
        addr_q[af_tag_i] <= af_addr_i;
        av_q[af_tag_i]   <= 1'b1;
      end
      if (df_valid_i && vld_q[df_tag_i] && !dv_q[df_tag_i]) begin
        data_q[df_tag_i] <= df_data_i;
        dv_q[df_tag_i]   <= 1'b1;
      end
      if (ret_go) begin
        rtd_q[rptr_q] <= 1'b1;
        rptr_q        <= nxt(rptr_q);
      end
      if (wr_done_i) begin
        vld_q[head_q] <= 1'b0;
        av_q[head_q]  <= 1'b0;
        dv_q[head_q]  <= 1'b0;
        rtd_q[head_q] <= 1'b0;
        head_q        <= nxt(head_q);
      end
      if (alloc_i) begin
        vld_q[tail_q]  <= 1'b1;
        av_q[tail_q]   <= alloc_av_i;
        dv_q[tail_q]   <= alloc_dv_i;
        rtd_q[tail_q]  <= 1'b0;
        addr_q[tail_q] <= alloc_addr_i;
        data_q[tail_q] <= alloc_data_i;
        size_q[tail_q] <= alloc_size_i;
        tail_q         <= nxt(tail_q);
      end
      cnt_q <= cnt_q + NW'(alloc_i) - NW'(wr_done_i);
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign vld_o  = vld_q;
  assign av_o   = av_q;
  assign dv_o   = dv_q;
  assign rtd_o  = rtd_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
  assign size_o = size_q;

  // R9
  occupancy_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= NW'(DEPTH));

  // R7
  empty_head_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> !vld_q[head_q]);
endmodule

// File: rtl/stb_match.sv
module stb_match import stb_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int AW = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int AX = AW + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [DEPTH-1:0]         vld_i,
  input  logic [DEPTH-1:0]         av_i,
  input  logic [DEPTH-1:0]         dv_i,
  input  logic [DEPTH-1:0][AW-1:0] addr_i,
  input  logic [DEPTH-1:0][DW-1:0] data_i,
  input  logic [DEPTH-1:0][1:0]    size_i,
  input  logic [IW-1:0]            tail_i,
  input  logic [AW-1:0]            ld_addr_i,
  input  logic [1:0]               ld_size_i,
  output logic [1:0]               res_o,
  output logic [1:0]               why_o,
  output logic [DW-1:0]            data_o
);
  logic [DEPTH-1:0] ovl, unk;
  logic [AX-1:0]    ld_lo, ld_hi;
  ld_res_e          res;
  blk_why_e         why;

  assign ld_lo = {1'b0, ld_addr_i};
  assign ld_hi = ld_lo + AX'(sz_bytes(ld_size_i));

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic [AX-1:0] st_lo, st_hi;
    assign st_lo  = {1'b0, addr_i[g]};
    assign st_hi  = st_lo + AX'(sz_bytes(size_i[g]));
    assign ovl[g] = vld_i[g] & av_i[g] & (st_lo < ld_hi) & (ld_lo < st_hi);
    assign unk[g] = vld_i[g] & ~av_i[g];
  end

  // youngest-first scan; first overlapping or unknown-address entry decides
  always_comb begin
    logic found;
    found  = 1'b0;
    res    = LD_PASS;
    why    = WHY_NONE;
    data_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [IW-1:0] ix;
      ix = IW'((int'(tail_i) + 2 * DEPTH - 1 - k) % DEPTH);
      if (!found && (unk[ix] || ovl[ix])) begin
        found = 1'b1;
        if (unk[ix]) begin
          res = LD_BLK;
          why = WHY_ADDR;
        end else if (!dv_i[ix]) begin
          res = LD_BLK;
          why = WHY_DATA;
        end else if (addr_i[ix] == ld_addr_i &&
                     sz_bytes(ld_size_i) <= sz_bytes(size_i[ix])) begin
          res = LD_FWD;
          case (ld_size_i)
            2'd0:    data_o = {24'b0, data_i[ix][7:0]};
            2'd1:    data_o = {16'b0, data_i[ix][15:0]};
            default: data_o = data_i[ix];
          endcase
        end else begin
          res = LD_BLK;
          why = WHY_PART;
        end
      end
    end
  end

  assign res_o = res;
  assign why_o = why;

  // R2
  pass_needs_known_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_o == LD_PASS) |-> ((vld_i & ~av_i) == '0));
endmodule

// File: rtl/stb_evt_cnt.sv
module stb_evt_cnt import stb_pkg::*; #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ev_i,
  input  logic [1:0]    why_i,
  output logic [CW-1:0] tot_o,
  output logic [CW-1:0] addr_o,
  output logic [CW-1:0] data_o,
  output logic [CW-1:0] part_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tot_o  <= '0;
      addr_o <= '0;
      data_o <= '0;
      part_o <= '0;
    end else if (ev_i) begin
      tot_o <= tot_o + 1'b1;
      case (why_i)
        WHY_ADDR: addr_o <= addr_o + 1'b1;
        WHY_DATA: data_o <= data_o + 1'b1;
        WHY_PART: part_o <= part_o + 1'b1;
        default:  ;
      endcase
    end
  end

  // R6
  reason_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tot_o == CW'(addr_o + data_o + part_o));

  // R6
  total_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i |=> tot_o == CW'($past(tot_o) + 1'b1));
endmodule

// File: rtl/stb_fwd.sv
module stb_fwd import stb_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int AW = 16,
  parameter int CW = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_valid_i,
  output logic          st_ready_o,
  input  logic [AW-1:0] st_addr_i,
  input  logic          st_addr_vld_i,
  input  logic [DW-1:0] st_data_i,
  input  logic          st_data_vld_i,
  input  logic [1:0]    st_size_i,
  output logic [IW-1:0] st_tag_o,
  input  logic          af_valid_i,
  input  logic [IW-1:0] af_tag_i,
  input  logic [AW-1:0] af_addr_i,
  input  logic          df_valid_i,
  input  logic [IW-1:0] df_tag_i,
  input  logic [DW-1:0] df_data_i,
  input  logic          retire_i,
  output logic          mem_wr_valid_o,
  input  logic          mem_wr_ready_i,
  output logic [AW-1:0] mem_wr_addr_o,
  output logic [1:0]    mem_wr_size_o,
  output logic [DW-1:0] mem_wr_data_o,
  input  logic          ld_valid_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [1:0]    ld_size_i,
  output logic [1:0]    ld_res_o,
  output logic [1:0]    ld_why_o,
  output logic [DW-1:0] ld_data_o,
  output logic [CW-1:0] blk_cnt_o,
  output logic [CW-1:0] blk_addr_cnt_o,
  output logic [CW-1:0] blk_data_cnt_o,
  output logic [CW-1:0] blk_part_cnt_o
);
  logic [DEPTH-1:0]         vld, av, dv, rtd;
  logic [DEPTH-1:0][AW-1:0] addr;
  logic [DEPTH-1:0][DW-1:0] data;
  logic [DEPTH-1:0][1:0]    size;
  logic [IW-1:0]            head, tail;
  logic                     full, alloc, wr_done, blk_ev;

  assign st_ready_o     = ~full;
  assign alloc          = st_valid_i & ~full;
  assign st_tag_o       = tail;
  assign mem_wr_valid_o = vld[head] & rtd[head] & av[head] & dv[head];
  assign mem_wr_addr_o  = addr[head];
  assign mem_wr_size_o  = size[head];
  assign mem_wr_data_o  = data[head];
  assign wr_done        = mem_wr_valid_o & mem_wr_ready_i;
  assign blk_ev         = ld_valid_i & (ld_res_o == LD_BLK);

  stb_entries #(.DEPTH(DEPTH), .AW(AW)) u_entries (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_i      (alloc),
    .alloc_addr_i (st_addr_i),
    .alloc_av_i   (st_addr_vld_i),
    .alloc_data_i (st_data_i),
    .alloc_dv_i   (st_data_vld_i),
    .alloc_size_i (st_size_i),
    .af_valid_i   (af_valid_i),
    .af_tag_i     (af_tag_i),
    .af_addr_i    (af_addr_i),
    .df_valid_i   (df_valid_i),
    .df_tag_i     (df_tag_i),
    .df_data_i    (df_data_i),
    .retire_i     (retire_i),
    .wr_done_i    (wr_done),
    .full_o       (full),
    .head_o       (head),
    .tail_o       (tail),
    .vld_o        (vld),
    .av_o         (av),
    .dv_o         (dv),
    .rtd_o        (rtd),
    .addr_o       (addr),
    .data_o       (data),
    .size_o       (size)
  );

  stb_match #(.DEPTH(DEPTH), .AW(AW)) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (vld),
    .av_i      (av),
    .dv_i      (dv),
    .addr_i    (addr),
    .data_i    (data),
    .size_i    (size),
    .tail_i    (tail),
    .ld_addr_i (ld_addr_i),
    .ld_size_i (ld_size_i),
    .res_o     (ld_res_o),
    .why_o     (ld_why_o),
    .data_o    (ld_data_o)
  );

  stb_evt_cnt #(.CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (blk_ev),
    .why_i  (ld_why_o),
    .tot_o  (blk_cnt_o),
    .addr_o (blk_addr_cnt_o),
    .data_o (blk_data_cnt_o),
    .part_o (blk_part_cnt_o)
  );

  // R7
  drain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_valid_o && !mem_wr_ready_i |=> mem_wr_valid_o && $stable(mem_wr_addr_o)
      && $stable(mem_wr_data_o) && $stable(mem_wr_size_o));
endmodule

// File: tb/stb_fwd_tb_top.sv
module stb_fwd_tb_top;
  localparam int DEPTH = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        st_valid_i = 0, st_addr_vld_i = 0, st_data_vld_i = 0;
  logic        st_ready_o;
  logic [15:0] st_addr_i = '0;
  logic [31:0] st_data_i = '0;
  logic [1:0]  st_size_i = '0;
  logic [2:0]  st_tag_o;
  logic        af_valid_i = 0, df_valid_i = 0, retire_i = 0;
  logic [2:0]  af_tag_i = '0, df_tag_i = '0;
  logic [15:0] af_addr_i = '0;
  logic [31:0] df_data_i = '0;
  logic        mem_wr_valid_o, mem_wr_ready_i = 0;
  logic [15:0] mem_wr_addr_o;
  logic [1:0]  mem_wr_size_o;
  logic [31:0] mem_wr_data_o;
  logic        ld_valid_i = 0;
  logic [15:0] ld_addr_i = '0;
  logic [1:0]  ld_size_i = '0;
  logic [1:0]  ld_res_o, ld_why_o;
  logic [31:0] ld_data_o;
  logic [15:0] blk_cnt_o, blk_addr_cnt_o, blk_data_cnt_o, blk_part_cnt_o;

  always #10ns clk_i = ~clk_i;

  stb_fwd dut_i (.*);

  typedef struct {
    int          tag;
    logic [15:0] addr;
    bit          av;
    logic [31:0] data;
    bit          dv;
    logic [1:0]  sz;
    bit          rtd;
  } ent_t;

  ent_t        q[$];
  int          m_tail = 0;
  logic [15:0] m_tot = 0, m_a = 0, m_d = 0, m_p = 0;
  int          nchk = 0, nfail = 0;
  string       cur_req = "R1";
  bit          done = 0;

  function automatic int nbytes(logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] mask(int n);
    return (n == 1) ? 32'hFF : (n == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic void ld_eval(output int r, output int w, output logic [31:0] d);
    int la, lb;
    bit hit;
    r = 0; w = 0; d = '0; hit = 0;
    la = int'(ld_addr_i);
    lb = nbytes(ld_size_i);
    for (int k = q.size() - 1; k >= 0; k--) begin
      int sa, sb;
      sa = int'(q[k].addr);
      sb = nbytes(q[k].sz);
      if (!hit) begin
        if (!q[k].av) begin
          r = 2; w = 1; hit = 1;
        end else if (sa < la + lb && la < sa + sb) begin
          hit = 1;
          if (!q[k].dv) begin r = 2; w = 2; end
          else if (sa == la && lb <= sb) begin r = 1; d = q[k].data & mask(lb); end
          else begin r = 2; w = 3; end
        end
      end
    end
  endfunction

  function automatic bit exp_mv();
    return q.size() > 0 && q[0].rtd && q[0].av && q[0].dv;
  endfunction

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    int r, w;
    logic [31:0] d;
    bit mv;
    ld_eval(r, w, d);
    mv = exp_mv();
    check("st_ready", 32'(st_ready_o), 32'(q.size() < DEPTH));
    check("st_tag", 32'(st_tag_o), 32'(m_tail));
    check("mem_wr_valid", 32'(mem_wr_valid_o), 32'(mv));
    if (mv) begin
      check("mem_wr_addr", 32'(mem_wr_addr_o), 32'(q[0].addr));
      check("mem_wr_size", 32'(mem_wr_size_o), 32'(q[0].sz));
      check("mem_wr_data", mem_wr_data_o, q[0].data);
    end
    check("ld_res", 32'(ld_res_o), 32'(r));
    check("ld_why", 32'(ld_why_o), 32'(w));
    check("ld_data", ld_data_o, d);
    check("blk_cnt", 32'(blk_cnt_o), 32'(m_tot));
    check("blk_addr_cnt", 32'(blk_addr_cnt_o), 32'(m_a));
    check("blk_data_cnt", 32'(blk_data_cnt_o), 32'(m_d));
    check("blk_part_cnt", 32'(blk_part_cnt_o), 32'(m_p));
  endtask

  task automatic model_step();
    int r, w;
    logic [31:0] d;
    bit mv, acc, rd;
    ent_t e;
    ld_eval(r, w, d);
    mv  = exp_mv();
    acc = st_valid_i && q.size() < DEPTH;
    foreach (q[i]) begin
      if (af_valid_i && q[i].tag == int'(af_tag_i) && !q[i].av) begin
        q[i].addr = af_addr_i; q[i].av = 1;
      end
      if (df_valid_i && q[i].tag == int'(df_tag_i) && !q[i].dv) begin
        q[i].data = df_data_i; q[i].dv = 1;
      end
    end
    if (retire_i) begin
      rd = 0;
      foreach (q[i]) if (!rd && !q[i].rtd) begin q[i].rtd = 1; rd = 1; end
    end
    if (ld_valid_i && r == 2) begin
      m_tot++;
      if (w == 1) m_a++;
      else if (w == 2) m_d++;
      else m_p++;
    end
    if (mv && mem_wr_ready_i) void'(q.pop_front());
    if (acc) begin
      e.tag = m_tail; e.addr = st_addr_i; e.av = st_addr_vld_i;
      e.data = st_data_i; e.dv = st_data_vld_i; e.sz = st_size_i; e.rtd = 0;
      q.push_back(e);
      m_tail = (m_tail + 1) % DEPTH;
    end
  endtask

  task automatic cyc();
    #2ns;
    compare();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
  endtask

  task automatic store(logic [15:0] a, logic [1:0] s, logic [31:0] dt, bit av, bit dv);
    st_valid_i = 1; st_addr_i = a; st_size_i = s; st_data_i = dt;
    st_addr_vld_i = av; st_data_vld_i = dv;
    cyc();
    st_valid_i = 0;
  endtask

  task automatic ld(logic [15:0] a, logic [1:0] s);
    ld_valid_i = 1; ld_addr_i = a; ld_size_i = s;
  endtask

  task automatic afill(logic [2:0] t, logic [15:0] a);
    af_valid_i = 1; af_tag_i = t; af_addr_i = a;
    cyc();
    af_valid_i = 0;
  endtask

  task automatic dfill(logic [2:0] t, logic [31:0] dt);
    df_valid_i = 1; df_tag_i = t; df_data_i = dt;
    cyc();
    df_valid_i = 0;
  endtask

  task automatic retire();
    retire_i = 1;
    cyc();
    retire_i = 0;
  endtask

  initial begin
    #1ns rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    cur_req = "R1";
    cyc(); cyc();

    cur_req = "R2";
    ld(16'h0200, 2); cyc();
    store(16'h0100, 2, 32'hA1B2C3D4, 1, 1);            // tag0
    ld(16'h0104, 2); cyc();
    ld(16'h00FC, 2); cyc();
    ld(16'h00FF, 0); cyc();

    cur_req = "R3";
    ld(16'h0100, 0); cyc();
    ld(16'h0100, 1); cyc();
    ld(16'h0100, 2); cyc();
    ld(16'h0100, 3); cyc();

    cur_req = "R5";
    ld(16'h0101, 0); cyc();
    ld(16'h00FF, 1); cyc();
    ld(16'h0102, 1); cyc();
    store(16'h0200, 1, 32'h99995566, 1, 1);            // tag1
    ld(16'h0200, 2); cyc();
    store(16'h0300, 2, 32'h0, 1, 0);                   // tag2, data unknown
    ld(16'h0300, 2); cyc();

    cur_req = "R10";
    dfill(3'd2, 32'h11223344);
    cyc();

    cur_req = "R5";
    store(16'h0000, 2, 32'hCAFEF00D, 0, 1);            // tag3, address unknown
    ld(16'h0400, 0); cyc();
    ld(16'h0100, 2); cyc();

    cur_req = "R10";
    afill(3'd3, 16'h0500);
    ld(16'h0500, 2); cyc();
    afill(3'd6, 16'h0100);                             // free tag, ignored

    cur_req = "R6";
    ld(16'h0101, 0); ld_valid_i = 0; cyc(); cyc();

    cur_req = "R4";
    store(16'h0100, 2, 32'hDEADBEEF, 1, 1);            // tag4, younger match
    ld(16'h0100, 2); cyc();
    store(16'h0102, 0, 32'h77, 1, 1);                  // tag5, younger partial
    ld(16'h0100, 2); cyc();
    ld(16'h0100, 0); cyc();

    cur_req = "R10";
    store(16'h0000, 2, 32'h0BADC0DE, 0, 1);            // tag6, address unknown
    ld(16'h0700, 0); cyc();
    afill(3'd6, 16'h0600);
    cyc();

    cur_req = "R9";
    store(16'h0700, 2, 32'h5A5A5A5A, 1, 1);            // tag7, now full
    st_valid_i = 1; st_addr_i = 16'h0800; st_size_i = 2;
    st_data_i = 32'h12345678; st_addr_vld_i = 1; st_data_vld_i = 1;
    cyc(); cyc();
    st_valid_i = 0;

    cur_req = "R7";
    ld_valid_i = 0;
    mem_wr_ready_i = 0;
    retire();
    cyc(); cyc();
    mem_wr_ready_i = 1; cyc();
    mem_wr_ready_i = 0;
    retire();

    cur_req = "R11";
    ld(16'h0200, 1);
    mem_wr_ready_i = 1; cyc();
    mem_wr_ready_i = 0; cyc();

    cur_req = "R8";
    mem_wr_ready_i = 1;
    for (int i = 0; i < 12; i++) retire();
    retire(); cyc();
    mem_wr_ready_i = 0;

    cur_req = "R9";
    for (int i = 0; i < 9; i++) store(16'(16'h0900 + 4 * i), 2, 32'(i), 1, 1);
    cyc();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #4ms;
    if (!done) begin
      nfail++;
      $display("FAIL %s watchdog act=running exp=finished", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule